// File: doc/BRIEF.md
# SHA-1 Compression Core with In-Memory Message Schedule

This block computes the SHA-1 digest of a message that has already been padded and split into 512-bit blocks. The blocks sit one after another in an external 32-bit word-addressed RAM, sixteen words per block, starting at a base address. A caller puts the base address and the block count on the inputs and pulses `start`. The core then walks the blocks on a fixed schedule and leaves the 160-bit result in five output registers.

The core keeps no copy of the sixteen-word schedule window. It reads the operands of each expanded word from the RAM and writes the new word back over the oldest word of the window. A processed block's RAM contents are therefore replaced by the last sixteen schedule words. Every block costs 342 cycles:

- 16 load rounds, one word read per round;
- 64 expanded rounds of five cycles each;
- five cycles that add the working variables into the hash;
- one cycle that prepares the next block.

Start-up adds three cycles.

Top module: `sha1_ram_core`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy`, `done`, `ram_sel` and `ram_we` are all 0.
- R2: A `start` sampled while idle is accepted. It latches `blk_cnt` and `base_addr`, and `busy` is 1 from the next cycle. In that cycle `done` is 0.
- R3: For n blocks, `done` rises on the clock edge 3 + 342·n edges after the edge that accepted `start`. `busy` falls on that same edge.
- R4: With `blk_cnt` = 0, the outputs hold 67452301, EFCDAB89, 98BADCFE, 10325476 and C3D2E1F0 (in `dig_a` to `dig_e` order) when `done` rises 3 edges after start.
- R5: The digest is the SHA-1 chaining over the blocks. It starts from the R4 values and uses Ch, parity, Maj and parity for rounds 0–19, 20–39, 40–59 and 60–79, with constants 5A827999, 6ED9EBA1, 8F1BBCDC and CA62C1D6. The temporary value is rotl5(A) + f + E + K + W mod 2^32. The five working variables are added into the hash after each block.
- R6: Block k (k = 0..n−1) is read from words base + 16·k .. base + 16·k + 15, word i of a block being schedule word W_i. Read data is taken one cycle after its address is presented with `ram_sel` high.
- R7: After a run, word j of every processed block holds W_{64+j}, where W_t = rotl1(W_{t−3} xor W_{t−8} xor W_{t−14} xor W_{t−16}). Each expanded word goes to slot t mod 16 of its block.
- R8: RAM words outside the processed blocks, including the word just below the base and the word just past the last block, are never written.
- R9: A `start` pulse while `busy` is 1 has no effect. The run's digest, timing and RAM region stay as if no pulse had occurred.
- R10: Once set, `done` and the digest outputs hold while idle. The next accepted `start` clears `done`.
- R11: `ram_we` is high only in cycles where `ram_sel` is high.
- R12: Every round sets A to the temporary value, B to the old A, C to the old B rotated left by 30, D to the old C and E to the old D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (honoured only when idle) |
| blk_cnt | input | 6 | Number of 512-bit blocks to hash |
| base_addr | input | 12 | Word address of the first block |
| ram_rdata | input | 32 | RAM read data, one cycle after the address |
| ram_addr | output | 12 | RAM word address |
| ram_sel | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write strobe, valid with `ram_sel` |
| ram_wdata | output | 32 | Expanded schedule word to write |
| busy | output | 1 | Run in progress |
| done | output | 1 | Digest valid |
| dig_a | output | 32 | Hash word 0 |
| dig_b | output | 32 | Hash word 1 |
| dig_c | output | 32 | Hash word 2 |
| dig_d | output | 32 | Hash word 3 |
| dig_e | output | 32 | Hash word 4 |

## Verification
The result of a run with n blocks is due exactly 3 + 342·n edges after the edge that takes `start`. `busy` is due one edge after that edge. The bench notes the cycle number when it drives `start` and queues the expected digest together with its due cycle. On every falling edge, a monitor waits for `done` to rise, then compares both the digest and the cycle of arrival. The RAM window and the guard words are examined only after `done`, when the core no longer touches memory.

// File: rtl/sha1_pkg.sv
`timescale 1ns/1ps
package sha1_pkg;

  typedef logic [31:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
  } wv_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_LOAD,
    ST_EXP,
    ST_ADD,
    ST_NEXT
  } st_t;

  localparam wv_t HASH_IV = '{
    a: 32'h67452301,
    b: 32'hEFCDAB89,
    c: 32'h98BADCFE,
    d: 32'h10325476,
    e: 32'hC3D2E1F0
  };

  function automatic word_t rotl1(word_t x);
    return {x[30:0], x[31]};
  endfunction

  function automatic word_t rotl5(word_t x);
    return {x[26:0], x[31:27]};
  endfunction

  function automatic word_t rotl30(word_t x);
    return {x[1:0], x[31:2]};
  endfunction

  // boolean function of the round group
  function automatic word_t mix_f(logic [6:0] t, word_t b, word_t c, word_t d);
    if (t < 7'd20)      return (b & c) | (~b & d);
    else if (t < 7'd40) return b ^ c ^ d;
    else if (t < 7'd60) return (b & c) | (b & d) | (c & d);
    else                return b ^ c ^ d;
  endfunction

  function automatic word_t k_of(logic [6:0] t);
    if (t < 7'd20)      return 32'h5A827999;
    else if (t < 7'd40) return 32'h6ED9EBA1;
    else if (t < 7'd60) return 32'h8F1BBCDC;
    else                return 32'hCA62C1D6;
  endfunction

  function automatic wv_t round_step(wv_t v, word_t w, logic [6:0] t);
    wv_t n;
    n.a = rotl5(v.a) + mix_f(t, v.b, v.c, v.d) + v.e + k_of(t) + w;
    n.b = v.a;
    n.c = rotl30(v.b);
    n.d = v.c;
    n.e = v.d;
    return n;
  endfunction

endpackage

// File: rtl/sha1_ctrl.sv
`timescale 1ns/1ps
module sha1_ctrl
  import sha1_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  nb_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              ram_sel_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              init_o,
  output logic              round_o,
  output logic              src_exp_o,
  output logic [6:0]        round_idx_o,
  output logic              acc_load_o,
  output logic              acc_xor_o,
  output logic              add_en_o,
  output logic [2:0]        add_idx_o,
  output logic              reload_o
);

  localparam int PAD   = ADDR_W - CNT_W - 4;
  localparam int SPAD  = ADDR_W - 4;
  localparam logic [6:0] RND_LOAD_LAST = 7'd15;
  localparam logic [6:0] RND_FIRST_EXP = 7'd16;
  localparam logic [6:0] RND_LAST      = 7'd79;
  localparam logic [2:0] INIT_LAST     = 3'd2;
  localparam logic [2:0] PH_LAST       = 3'd4;
  localparam logic [2:0] ADD_LAST      = 3'd4;

  st_t               st_q;
  logic [2:0]        cnt_q;
  logic [6:0]        rnd_q;
  logic [CNT_W-1:0]  bl_q, nb_q;
  logic [ADDR_W-1:0] base_q;
  logic              busy_q, done_q;
  logic [CNT_W-1:0]  bl_dec;
  logic [ADDR_W-1:0] cur_blk, nxt_blk;
  logic [3:0]        slot_now;

  function automatic logic [ADDR_W-1:0] blk_start(logic [ADDR_W-1:0] b,
                                                  logic [CNT_W-1:0] total,
                                                  logic [CNT_W-1:0] left);
    logic [CNT_W-1:0] idx;
    idx = total - left;
    return b + {{PAD{1'b0}}, idx, 4'b0000};
  endfunction

  function automatic logic [ADDR_W-1:0] at_slot(logic [ADDR_W-1:0] blk, logic [3:0] s);
    return blk + {{SPAD{1'b0}}, s};
  endfunction

  assign bl_dec   = bl_q - 1'b1;
  assign cur_blk  = blk_start(base_q, nb_q, bl_q);
  assign nxt_blk  = blk_start(base_q, nb_q, bl_dec);
  assign slot_now = rnd_q[3:0];

  always_comb begin
    ram_sel_o  = 1'b0;
    ram_we_o   = 1'b0;
    ram_addr_o = '0;
    init_o     = 1'b0;
    round_o    = 1'b0;
    src_exp_o  = 1'b0;
    acc_load_o = 1'b0;
    acc_xor_o  = 1'b0;
    add_en_o   = 1'b0;
    add_idx_o  = cnt_q;
    reload_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: init_o = start_i;
      ST_INIT: begin
        if (cnt_q == INIT_LAST) begin
          ram_sel_o  = 1'b1;
          ram_addr_o = at_slot(cur_blk, 4'd0);
        end
      end
      ST_LOAD: begin
        round_o = 1'b1;
        if (rnd_q != RND_LOAD_LAST) begin
          ram_sel_o  = 1'b1;
          ram_addr_o = at_slot(cur_blk, 4'(slot_now + 4'd1));
        end
      end
      ST_EXP: begin
        ram_sel_o = 1'b1;
        unique case (cnt_q)
          3'd0: ram_addr_o = at_slot(cur_blk, 4'(slot_now + 4'd13));
          3'd1: begin
            acc_load_o = 1'b1;
            ram_addr_o = at_slot(cur_blk, 4'(slot_now + 4'd8));
          end
          3'd2: begin
            acc_xor_o  = 1'b1;
            ram_addr_o = at_slot(cur_blk, 4'(slot_now + 4'd2));
          end
          3'd3: begin
            acc_xor_o  = 1'b1;
            ram_addr_o = at_slot(cur_blk, slot_now);
          end
          default: begin
            ram_we_o   = 1'b1;
            round_o    = 1'b1;
            src_exp_o  = 1'b1;
            ram_addr_o = at_slot(cur_blk, slot_now);
          end
        endcase
      end
      ST_ADD: add_en_o = 1'b1;
      ST_NEXT: begin
        reload_o   = 1'b1;
        ram_sel_o  = (bl_dec != '0);
        ram_addr_o = at_slot(nxt_blk, 4'd0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rnd_q  <= '0;
      bl_q   <= '0;
      nb_q   <= '0;
      base_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            done_q <= 1'b0;
            busy_q <= 1'b1;
            nb_q   <= nb_i;
            bl_q   <= nb_i;
            base_q <= base_i;
            cnt_q  <= '0;
            st_q   <= ST_INIT;
          end
        end
        ST_INIT: begin
          if (cnt_q == INIT_LAST) begin
            cnt_q <= '0;
            rnd_q <= '0;
            if (bl_q == '0) begin
              done_q <= 1'b1;
              busy_q <= 1'b0;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_LOAD;
            end
          end else begin
            cnt_q <= cnt_q + 3'd1;
          end
        end
        ST_LOAD: begin
          if (rnd_q == RND_LOAD_LAST) begin
            rnd_q <= RND_FIRST_EXP;
            cnt_q <= '0;
            st_q  <= ST_EXP;
          end else begin
            rnd_q <= rnd_q + 7'd1;
          end
        end
        ST_EXP: begin
          if (cnt_q == PH_LAST) begin
            cnt_q <= '0;
            if (rnd_q == RND_LAST) st_q <= ST_ADD;
            else                   rnd_q <= rnd_q + 7'd1;
          end else begin
            cnt_q <= cnt_q + 3'd1;
          end
        end
        ST_ADD: begin
          if (cnt_q == ADD_LAST) begin
            cnt_q <= '0;
            st_q  <= ST_NEXT;
          end else begin
            cnt_q <= cnt_q + 3'd1;
          end
        end
        ST_NEXT: begin
          bl_q  <= bl_dec;
          rnd_q <= '0;
          if (bl_dec == '0) begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_LOAD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign round_idx_o = rnd_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && start_i) |=> busy_q);

  // R3
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $fell(busy_q));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start_i) |=> done_q);

  // R9
  busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(nb_q) && $stable(base_q)));

  // R11
  we_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |-> ram_sel_o);

endmodule

// File: rtl/sha1_sched.sv
`timescale 1ns/1ps
module sha1_sched
  import sha1_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  acc_load_i,
  input  logic  acc_xor_i,
  input  word_t rdata_i,
  output word_t wexp_o
);

  word_t acc_q;

  always_ff @(posedge clk) begin
    if (rst)             acc_q <= '0;
    else if (acc_load_i) acc_q <= rdata_i;
    else if (acc_xor_i)  acc_q <= acc_q ^ rdata_i;
  end

  // fourth operand arrives on the write cycle
  assign wexp_o = rotl1(acc_q ^ rdata_i);

endmodule

// File: rtl/sha1_state.sv
`timescale 1ns/1ps
module sha1_state
  import sha1_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       init_i,
  input  logic       round_i,
  input  logic       src_exp_i,
  input  logic [6:0] round_idx_i,
  input  word_t      rdata_i,
  input  word_t      wexp_i,
  input  logic       add_en_i,
  input  logic [2:0] add_idx_i,
  input  logic       reload_i,
  output wv_t        hash_o
);

  wv_t   wv_q, h_q;
  word_t w_in;

  assign w_in = src_exp_i ? wexp_i : rdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wv_q <= '0;
      h_q  <= HASH_IV;
    end else if (init_i) begin
      wv_q <= HASH_IV;
      h_q  <= HASH_IV;
    end else begin
      if (round_i)       wv_q <= round_step(wv_q, w_in, round_idx_i);
      else if (reload_i) wv_q <= h_q;
      if (add_en_i) begin
        unique case (add_idx_i)
          3'd0:    h_q.a <= h_q.a + wv_q.a;
          3'd1:    h_q.b <= h_q.b + wv_q.b;
          3'd2:    h_q.c <= h_q.c + wv_q.c;
          3'd3:    h_q.d <= h_q.d + wv_q.d;
          default: h_q.e <= h_q.e + wv_q.e;
        endcase
      end
    end
  end

  assign hash_o = h_q;

  // R5
  hash_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!add_en_i && !init_i) |=> $stable(h_q));

  // R12
  round_shift_chk: assert property (@(posedge clk) disable iff (rst)
    round_i |=> (wv_q.b == $past(wv_q.a)) && (wv_q.c == rotl30($past(wv_q.b)))
                && (wv_q.d == $past(wv_q.c)) && (wv_q.e == $past(wv_q.d)));

endmodule

// File: rtl/sha1_ram_core.sv
`timescale 1ns/1ps
module sha1_ram_core
  import sha1_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  blk_cnt,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [31:0]       ram_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [31:0]       ram_wdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       dig_a,
  output logic [31:0]       dig_b,
  output logic [31:0]       dig_c,
  output logic [31:0]       dig_d,
  output logic [31:0]       dig_e
);

  logic       ev_init, ev_round, ev_src_exp, ev_acc_load, ev_acc_xor;
  logic       ev_add, ev_reload;
  logic [6:0] round_idx;
  logic [2:0] add_idx;
  word_t      wexp;
  wv_t        hash;

  sha1_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .nb_i        (blk_cnt),
    .base_i      (base_addr),
    .ram_sel_o   (ram_sel),
    .ram_we_o    (ram_we),
    .ram_addr_o  (ram_addr),
    .busy_o      (busy),
    .done_o      (done),
    .init_o      (ev_init),
    .round_o     (ev_round),
    .src_exp_o   (ev_src_exp),
    .round_idx_o (round_idx),
    .acc_load_o  (ev_acc_load),
    .acc_xor_o   (ev_acc_xor),
    .add_en_o    (ev_add),
    .add_idx_o   (add_idx),
    .reload_o    (ev_reload)
  );

  sha1_sched u_sched (
    .clk        (clk),
    .rst        (rst),
    .acc_load_i (ev_acc_load),
    .acc_xor_i  (ev_acc_xor),
    .rdata_i    (ram_rdata),
    .wexp_o     (wexp)
  );

  sha1_state u_state (
    .clk         (clk),
    .rst         (rst),
    .init_i      (ev_init),
    .round_i     (ev_round),
    .src_exp_i   (ev_src_exp),
    .round_idx_i (round_idx),
    .rdata_i     (ram_rdata),
    .wexp_i      (wexp),
    .add_en_i    (ev_add),
    .add_idx_i   (add_idx),
    .reload_i    (ev_reload),
    .hash_o      (hash)
  );

  assign ram_wdata = wexp;
  assign dig_a = hash.a;
  assign dig_b = hash.b;
  assign dig_c = hash.c;
  assign dig_d = hash.d;
  assign dig_e = hash.e;

  // R10
  digest_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable({dig_a, dig_b, dig_c, dig_d, dig_e}));

endmodule

// File: tb/test_sha1_ram_core.sv
`timescale 1ns/1ps
module test_sha1_ram_core;

  localparam logic [159:0] IV_B =
    160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
  localparam logic [159:0] ABC_DIG =
    160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  blk_cnt = '0;
  logic [11:0] base_addr = '0;
  logic [31:0] ram_rdata = '0;
  logic [11:0] ram_addr;
  logic        ram_sel, ram_we, busy, done;
  logic [31:0] ram_wdata, dig_a, dig_b, dig_c, dig_d, dig_e;

  logic [31:0] mem [0:1023];
  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  int we_bad = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [159:0] exp_dig_q [$];
  int           exp_cyc_q [$];

  sha1_ram_core i_sha1_ram_core (
    .clk(clk), .rst(rst), .start(start), .blk_cnt(blk_cnt), .base_addr(base_addr),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_sel(ram_sel), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .busy(busy), .done(done),
    .dig_a(dig_a), .dig_b(dig_b), .dig_c(dig_c), .dig_d(dig_d), .dig_e(dig_e)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // RAM model: registered read, write when select and strobe
  always @(posedge clk) begin
    if (ram_sel) begin
      if (ram_we) mem[ram_addr[9:0]] <= ram_wdata;
      ram_rdata <= mem[ram_addr[9:0]];
    end
  end

  function automatic logic [159:0] digest();
    return {dig_a, dig_b, dig_c, dig_d, dig_e};
  endfunction

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] rnd32();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // reference compression, also returns the last sixteen schedule words
  function automatic logic [159:0] ref_block(input logic [159:0] hin,
                                             input logic [511:0] blk,
                                             output logic [511:0] tail);
    logic [31:0] w [80];
    logic [31:0] v [5];
    logic [31:0] f, k, t;
    for (int i = 0; i < 80; i++) begin
      if (i < 16) w[i] = blk[511 - 32*i -: 32];
      else        w[i] = rl(w[i-16] ^ w[i-14] ^ w[i-8] ^ w[i-3], 1);
    end
    for (int i = 0; i < 5; i++) v[i] = hin[159 - 32*i -: 32];
    for (int i = 0; i < 80; i++) begin
      case (i / 20)
        0: begin f = (v[1] & v[2]) ^ (~v[1] & v[3]); k = 32'h5A827999; end
        1: begin f = v[1] ^ v[2] ^ v[3];             k = 32'h6ED9EBA1; end
        2: begin f = (v[1] & v[2]) ^ (v[1] & v[3]) ^ (v[2] & v[3]); k = 32'h8F1BBCDC; end
        default: begin f = v[1] ^ v[2] ^ v[3];       k = 32'hCA62C1D6; end
      endcase
      t = rl(v[0], 5) + f + v[4] + k + w[i];
      v[4] = v[3]; v[3] = v[2]; v[2] = rl(v[1], 30); v[1] = v[0]; v[0] = t;
    end
    for (int i = 0; i < 16; i++) tail[511 - 32*i -: 32] = w[64 + i];
    return {hin[159:128] + v[0], hin[127:96] + v[1], hin[95:64] + v[2],
            hin[63:32] + v[3], hin[31:0] + v[4]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    end
  endtask

  // monitor: pops the scoreboard when done rises
  initial begin
    logic done_prev;
    done_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (ram_we && !ram_sel) we_bad++;
        if (done && !done_prev) begin
          if (exp_dig_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected done", 512'(1), 512'(0));
          end else begin
            logic [159:0] ed;
            int ec;
            ed = exp_dig_q.pop_front();
            ec = exp_cyc_q.pop_front();
            // R5 R12 R6: digest of the chained blocks
            chk(digest() == ed, "R5", "digest", 512'(digest()), 512'(ed));
            chk(cyc == ec, "R3", "done cycle", 512'(cyc), 512'(ec));
            chk(busy == 1'b0, "R3", "busy at done", 512'(busy), 512'(0));
          end
        end
      end
      done_prev = done;
    end
  end

  task automatic fill_block(input logic [11:0] base, input int k, input bit rand_data);
    for (int i = 0; i < 16; i++)
      mem[10'(base + 16*k + i)] <= rand_data ? rnd32() : 32'h0;
  endtask

  task automatic run_job(input logic [11:0] base, input int n, input bit poke);
    logic [159:0] h;
    logic [511:0] blk, tail;
    logic [511:0] tails [8];
    logic [31:0]  g_lo, g_hi;
    h = IV_B;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 16; i++) blk[511 - 32*i -: 32] = mem[10'(base + 16*k + i)];
      h = ref_block(h, blk, tail);
      tails[k] = tail;
    end
    g_lo = mem[10'(base - 1)];
    g_hi = mem[10'(base + 16*n)];
    @(negedge clk);
    start = 1'b1; blk_cnt = 6'(n); base_addr = base;
    exp_dig_q.push_back(h);
    exp_cyc_q.push_back(cyc + 4 + 342*n);
    @(negedge clk);
    start = 1'b0; blk_cnt = 6'h3F; base_addr = 12'hFFF;
    chk(busy == 1'b1, "R2", "busy after start", 512'(busy), 512'(1));
    chk(done == 1'b0, "R10", "done cleared by start", 512'(done), 512'(0));
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1; blk_cnt = 6'd5; base_addr = 12'h000;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 16; i++) blk[511 - 32*i -: 32] = mem[10'(base + 16*k + i)];
      chk(blk == tails[k], "R7", "schedule window in RAM", blk, tails[k]);
    end
    chk(mem[10'(base - 1)] == g_lo, "R8", "guard below", 512'(mem[10'(base - 1)]), 512'(g_lo));
    chk(mem[10'(base + 16*n)] == g_hi, "R8", "guard above",
        512'(mem[10'(base + 16*n)]), 512'(g_hi));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R3 watchdog: actual timeout expected done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] <= 32'hA5A5_0000 + 32'(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, done, ram_sel, ram_we} == 4'b0, "R1", "outputs in reset",
        512'({busy, done, ram_sel, ram_we}), 512'(0));
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, ram_sel, ram_we} == 4'b0, "R1", "outputs after reset",
        512'({busy, done, ram_sel, ram_we}), 512'(0));

    // R4: zero blocks
    run_job(12'h010, 0, 1'b0);
    chk(digest() == IV_B, "R4", "initial hash", 512'(digest()), 512'(IV_B));

    // R5: one known block at an offset base
    fill_block(12'h040, 0, 1'b0);
    @(negedge clk);
    mem[12'h040] <= 32'h61626380;
    mem[12'h04F] <= 32'h00000018;
    @(negedge clk);
    run_job(12'h040, 1, 1'b0);
    chk(digest() == ABC_DIG, "R5", "known one-block digest", 512'(digest()), 512'(ABC_DIG));

    // R10: done and digest hold while idle
    begin
      logic [159:0] held;
      held = digest();
      repeat (20) @(negedge clk);
      chk(done == 1'b1, "R10", "done held", 512'(done), 512'(1));
      chk(digest() == held, "R10", "digest held", 512'(digest()), 512'(held));
    end

    // R6 R9: three random blocks, start pulsed mid-run
    for (int k = 0; k < 3; k++) fill_block(12'h100, k, 1'b1);
    @(negedge clk);
    run_job(12'h100, 3, 1'b1);

    // R6: two blocks near the top of the modelled RAM
    for (int k = 0; k < 2; k++) fill_block(12'h3C0, k, 1'b1);
    @(negedge clk);
    run_job(12'h3C0, 2, 1'b0);

    // R11: write strobe never without select
    chk(we_bad == 0, "R11", "strobe without select", 512'(we_bad), 512'(0));
    chk(exp_dig_q.size() == 0, "R3", "results outstanding",
        512'(exp_dig_q.size()), 512'(0));

    summary();
    $finish;
  end

endmodule